// File: doc/BRIEF.md
# I2C Interrupt Status and Clear Unit

This block gathers the event flags of an I2C controller into one interrupt line. The protocol engine and the queue logic signal events as single-cycle strobes. Most sources are latched into a raw status vector and stay set until software clears them. Two sources are not latched: receive-full and transmit-empty are computed every cycle from the current queue levels against programmable thresholds. A mask register selects which raw bits reach the masked status and the interrupt output.

Software clears a latched source by reading its own clear register. A single read of the combined clear register clears every latched source at once. A clearing read has no effect on the two level sources, which follow the queue levels. When an event strobe and a clearing read fall in the same cycle, the event takes priority and the flag remains set. The register interface is a simple single-cycle read/write port. Read data is combinational from the current state, and any clear takes effect at the clock edge that ends the read cycle.

Register word addresses: 0 mask (rw, 12 bits), 1 raw status (ro), 2 masked status (ro), 3 receive threshold (rw, 3 bits), 4 transmit threshold (rw, 3 bits), 5 combined clear (ro, bit 0 returns the OR of all latched flags), 8+k clear for source k (ro, bit 0 returns raw bit k). Any other address reads zero.

Top module: `i2c_irq_unit`

## Requirements
- R1: Status bit k is defined as follows: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop detected, 10 start detected, 11 general call. A strobe on `ev_pulse[k]` for a latched bit (every bit except 2 and 4) sets raw bit k from the next cycle on. The bit then holds until a clearing read.
- R2: The masked status (address 2) equals the raw status ANDed with the mask (address 0). `irq` is the OR of the masked status. A mask of zero keeps `irq` low.
- R3: A read of address 8+k returns raw bit k in bit 0 and clears latched bit k only. All other bits are unchanged.
- R4: A read of address 5 returns the OR of the latched flags in bit 0 and clears every latched bit. Raw bits 2 and 4 are unaffected.
- R5: Raw bit 2 (rx full) is 1 exactly when `rx_level` is greater than the receive threshold. It tracks the level in the same cycle and cannot be cleared by any read.
- R6: Raw bit 4 (tx empty) is 1 exactly when `tx_level` is at or below the transmit threshold. It tracks the level in the same cycle.
- R7: The threshold registers keep only bits [2:0] of a write and read back as values 0 to 7.
- R8: If an event strobe and a clearing read of that bit occur in the same cycle, the bit is set after the edge.
- R9: After reset, the mask, both thresholds and all latched flags are zero.
- R10: Strobes on `ev_pulse[2]` and `ev_pulse[4]` have no effect. Those raw bits reflect only the queue levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd | input | 1 | Register read strobe (single cycle, may clear) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed register |
| ev_pulse | input | 12 | Event strobes from the engine, one per status bit |
| rx_level | input | LVL_W | Current receive queue level |
| tx_level | input | LVL_W | Current transmit queue level |
| irq | output | 1 | Combined interrupt output |

## Verification
The assertions check several rules on every cycle:
- a zero mask silences `irq`, and a raised `irq` always has an unmasked raw bit behind it;
- a stop-detect strobe is always visible after the edge;
- a latched stop flag only drops after a read of its own or the combined clear register;
- those reads empty the flags when no strobe competes;
- rx-full follows the level comparison.

The bench scenarios cover the remaining behaviour:
- the exact bit position of each source;
- the read-back values of the clear registers;
- threshold truncation;
- transmit-empty at and around its threshold;
- ignored strobes on the level bits;
- the event-wins collision across random interleavings.

// File: rtl/i2c_irq_pkg.sv
`timescale 1ns/1ps
package i2c_irq_pkg;
    localparam int NSRC = 12;
    localparam int TL_W = 3;

    localparam int SRC_RX_FULL  = 2;
    localparam int SRC_TX_EMPTY = 4;
    localparam int SRC_STOP     = 9;

    // sources held in flops; bits 2 and 4 follow queue levels
    localparam logic [NSRC-1:0] LATCHED = 12'hFEB;

    localparam int A_MASK   = 0;
    localparam int A_RAW    = 1;
    localparam int A_MSTAT  = 2;
    localparam int A_RXTL   = 3;
    localparam int A_TXTL   = 4;
    localparam int A_CLRALL = 5;
    localparam int A_CLR0   = 8;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [TL_W-1:0] rx_tl;
        logic [TL_W-1:0] tx_tl;
    } cfg_t;
endpackage

// File: rtl/i2c_irq_decode.sv
`timescale 1ns/1ps
module i2c_irq_decode
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NSRC-1:0]   raw,
    input  logic [NSRC-1:0]   latched,
    input  cfg_t              cfg,
    output logic [NSRC-1:0]   clr_vec,
    output logic              wr_mask,
    output logic              wr_rxtl,
    output logic              wr_txtl,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        wr_mask = reg_wr && (reg_addr == ADDR_W'(A_MASK));
        wr_rxtl = reg_wr && (reg_addr == ADDR_W'(A_RXTL));
        wr_txtl = reg_wr && (reg_addr == ADDR_W'(A_TXTL));
    end

    always_comb begin
        clr_vec = '0;
        if (reg_rd && (reg_addr == ADDR_W'(A_CLRALL))) begin
            clr_vec = LATCHED;
        end
        for (int i = 0; i < NSRC; i++) begin
            if (reg_rd && (reg_addr == ADDR_W'(A_CLR0 + i))) begin
                clr_vec[i] = LATCHED[i];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (reg_addr)
            ADDR_W'(A_MASK):   rdata[NSRC-1:0] = cfg.mask;
            ADDR_W'(A_RAW):    rdata[NSRC-1:0] = raw;
            ADDR_W'(A_MSTAT):  rdata[NSRC-1:0] = raw & cfg.mask;
            ADDR_W'(A_RXTL):   rdata[TL_W-1:0] = cfg.rx_tl;
            ADDR_W'(A_TXTL):   rdata[TL_W-1:0] = cfg.tx_tl;
            ADDR_W'(A_CLRALL): rdata[0] = |latched;
            default: begin
                for (int i = 0; i < NSRC; i++) begin
                    if (reg_addr == ADDR_W'(A_CLR0 + i)) begin
                        rdata[0] = raw[i];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/i2c_irq_cfg.sv
`timescale 1ns/1ps
module i2c_irq_cfg
    import i2c_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_mask,
    input  logic            wr_rxtl,
    input  logic            wr_txtl,
    input  logic [NSRC-1:0] wdata,
    output cfg_t            cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_mask) cfg_d.mask  = wdata;
        if (wr_rxtl) cfg_d.rx_tl = wdata[TL_W-1:0];
        if (wr_txtl) cfg_d.tx_tl = wdata[TL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/i2c_irq_latch.sv
`timescale 1ns/1ps
module i2c_irq_latch
    import i2c_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] flags
);
    logic [NSRC-1:0] flag_d, flag_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (LATCHED[i]) begin : g_hold
            // the strobe wins over a clearing read in the same cycle
            assign flag_d[i] = ev[i] | (flag_q[i] & ~clr[i]);
        end else begin : g_none
            assign flag_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;
endmodule

// File: rtl/i2c_irq_level.sv
`timescale 1ns/1ps
module i2c_irq_level
    import i2c_irq_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [TL_W-1:0]  rx_tl,
    input  logic [TL_W-1:0]  tx_tl,
    output logic             rx_full,
    output logic             tx_empty
);
    always_comb begin
        rx_full  = int'(rx_level) >  int'(rx_tl);
        tx_empty = int'(tx_level) <= int'(tx_tl);
    end
endmodule

// File: rtl/i2c_irq_unit.sv
`timescale 1ns/1ps
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   ev_pulse,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    output logic              irq
);
    cfg_t            cfg;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] lat_flags;
    logic [NSRC-1:0] raw_stat;
    logic [NSRC-1:0] mask_val;
    logic [TL_W-1:0] rx_tl_val;
    logic            wr_mask, wr_rxtl, wr_txtl;
    logic            rx_full, tx_empty;
    logic            unused_wbits;

    assign unused_wbits = ^reg_wdata;

    i2c_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .raw      (raw_stat),
        .latched  (lat_flags),
        .cfg      (cfg),
        .clr_vec  (clr_vec),
        .wr_mask  (wr_mask),
        .wr_rxtl  (wr_rxtl),
        .wr_txtl  (wr_txtl),
        .rdata    (reg_rdata)
    );

    i2c_irq_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_rxtl (wr_rxtl),
        .wr_txtl (wr_txtl),
        .wdata   (reg_wdata[NSRC-1:0]),
        .cfg     (cfg)
    );

    i2c_irq_latch u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev_pulse),
        .clr   (clr_vec),
        .flags (lat_flags)
    );

    i2c_irq_level #(.LVL_W(LVL_W)) u_lvl (
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rx_tl    (cfg.rx_tl),
        .tx_tl    (cfg.tx_tl),
        .rx_full  (rx_full),
        .tx_empty (tx_empty)
    );

    always_comb begin
        raw_stat               = lat_flags;
        raw_stat[SRC_RX_FULL]  = rx_full;
        raw_stat[SRC_TX_EMPTY] = tx_empty;
        mask_val               = cfg.mask;
        rx_tl_val              = cfg.rx_tl;
        irq                    = |(raw_stat & cfg.mask);
    end
endmodule

// File: rtl/i2c_irq_chk.sv
`timescale 1ns/1ps
module i2c_irq_chk
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LVL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NSRC-1:0]   ev_pulse,
    input logic              irq,
    input logic [NSRC-1:0]   raw,
    input logic [NSRC-1:0]   mask,
    input logic [LVL_W-1:0]  rx_level,
    input logic [TL_W-1:0]   rx_tl
);
    logic stop_clr_rd, all_clr_rd;
    assign stop_clr_rd = reg_rd && (reg_addr == ADDR_W'(A_CLR0 + SRC_STOP));
    assign all_clr_rd  = reg_rd && (reg_addr == ADDR_W'(A_CLRALL));

    // R2
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R2
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & mask) != '0));

    // R8
    stop_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[SRC_STOP] |=> raw[SRC_STOP]);

    // R3
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_clr_rd && !ev_pulse[SRC_STOP]) |=> !raw[SRC_STOP]);

    // R4
    all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_clr_rd && (ev_pulse == '0)) |=> ((raw & LATCHED) == '0));

    // R1
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[SRC_STOP] && !stop_clr_rd && !all_clr_rd) |=> raw[SRC_STOP]);

    // R5
    rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw[SRC_RX_FULL] == (int'(rx_level) > int'(rx_tl)));
endmodule

bind i2c_irq_unit i2c_irq_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .ev_pulse (ev_pulse),
    .irq      (irq),
    .raw      (raw_stat),
    .mask     (mask_val),
    .rx_level (rx_level),
    .rx_tl    (rx_tl_val)
);

// File: tb/sim_i2c_irq_unit.sv
`timescale 1ns/1ps
module sim_i2c_irq_unit;
    localparam int AW = 5;
    localparam int DW = 16;
    localparam int LW = 4;
    localparam logic [11:0] LATM = 12'hFEB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_rd = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [11:0]   ev_pulse = '0;
    logic [LW-1:0] rx_level = '0;
    logic [LW-1:0] tx_level = '0;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [11:0] m_lat = '0;
    logic [11:0] m_mask = '0;
    logic [2:0]  m_rxt = '0;
    logic [2:0]  m_txt = '0;

    always #10 clk = ~clk;

    i2c_irq_unit #(.ADDR_W(AW), .DATA_W(DW), .LVL_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_pulse(ev_pulse), .rx_level(rx_level), .tx_level(tx_level),
        .irq(irq)
    );

    function automatic logic [11:0] raw_exp();
        logic [11:0] r;
        r = m_lat & LATM;
        r[2] = int'(rx_level) > int'(m_rxt);
        r[4] = int'(tx_level) <= int'(m_txt);
        return r;
    endfunction

    function automatic logic [DW-1:0] read_exp(input logic [AW-1:0] a);
        logic [DW-1:0] v;
        logic [11:0] r;
        v = '0;
        r = raw_exp();
        if (a == 0) v[11:0] = m_mask;
        else if (a == 1) v[11:0] = r;
        else if (a == 2) v[11:0] = r & m_mask;
        else if (a == 3) v[2:0] = m_rxt;
        else if (a == 4) v[2:0] = m_txt;
        else if (a == 5) v[0] = |(m_lat & LATM);
        else if (a >= 8 && a < 20) v[0] = r[a-8];
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one register/event cycle; read data and irq sampled before the edge
    task automatic op(input logic rd, input logic wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input logic [11:0] ev, input string tag);
        logic [11:0] clr;
        @(negedge clk);
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd; ev_pulse = ev;
        #2;
        if (rd) check(tag, 32'(reg_rdata), 32'(read_exp(a)));
        check({tag, " irq"}, 32'(irq), 32'(|(raw_exp() & m_mask)));
        @(posedge clk);
        clr = '0;
        if (rd && a == 5) clr = LATM;
        if (rd && a >= 8 && a < 20) clr = (12'd1 << (a - 8)) & LATM;
        m_lat = (ev & LATM) | (m_lat & ~clr);
        if (wr && a == 0) m_mask = wd[11:0];
        if (wr && a == 3) m_rxt = wd[2:0];
        if (wr && a == 4) m_txt = wd[2:0];
        #1;
        reg_rd = 1'b0; reg_wr = 1'b0; ev_pulse = '0;
    endtask

    task automatic levels(input logic [LW-1:0] rxl, input logic [LW-1:0] txl);
        @(negedge clk);
        rx_level = rxl; tx_level = txl;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5318));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9 reset state
        op(1, 0, 0, 0, 0, "R9 mask");
        op(1, 0, 3, 0, 0, "R9 rxtl");
        op(1, 0, 4, 0, 0, "R9 txtl");
        op(1, 0, 1, 0, 0, "R9 raw");

        // R7 threshold truncation
        op(0, 1, 3, 16'hFFFD, 0, "R7 wr");
        op(1, 0, 3, 0, 0, "R7 rxtl");
        op(0, 1, 4, 16'h000E, 0, "R7 wr");
        op(1, 0, 4, 0, 0, "R7 txtl");

        // R1 each latched position, then R3 clear each one
        for (int k = 0; k < 12; k++) begin
            if (LATM[k]) begin
                op(0, 0, 0, 0, 12'd1 << k, "R1 strobe");
                op(1, 0, 1, 0, 0, "R1 raw");
                op(1, 0, AW'(8 + k), 0, 0, "R3 clr read");
                op(1, 0, 1, 0, 0, "R3 raw after");
            end
        end

        // R10 strobes on level bits ignored
        op(0, 1, 4, 0, 0, "R10 wr");
        levels(4'd5, 4'd5);
        op(0, 0, 0, 0, 12'h014, "R10 strobe");
        op(1, 0, 1, 0, 0, "R10 raw");

        // R5 / R6 level edges
        op(0, 1, 3, 16'd3, 0, "R5 wr");
        op(0, 1, 4, 16'd3, 0, "R6 wr");
        levels(4'd3, 4'd3);
        op(1, 0, 1, 0, 0, "R5 R6 at thr");
        levels(4'd4, 4'd4);
        op(1, 0, 1, 0, 0, "R5 R6 above thr");
        op(1, 0, 5, 0, 0, "R5 clrall");
        op(1, 0, 8 + 2, 0, 0, "R5 clr rxfull");
        op(1, 0, 1, 0, 0, "R5 still set");

        // R4 combined clear, R2 mask gating
        op(0, 1, 0, 16'h0A04, 0, "R2 wr mask");
        op(0, 0, 0, 0, 12'hFEB, "R4 strobe all");
        op(1, 0, 2, 0, 0, "R2 masked");
        op(1, 0, 5, 0, 0, "R4 clrall");
        op(1, 0, 1, 0, 0, "R4 raw after");
        op(1, 0, 2, 0, 0, "R2 masked after");

        // R8 strobe and clearing read together
        op(0, 0, 0, 0, 12'h200, "R8 set");
        op(1, 0, 8 + 9, 0, 12'h200, "R8 collide");
        op(1, 0, 1, 0, 0, "R8 raw");
        op(1, 0, 5, 0, 12'h041, "R8 collide all");
        op(1, 0, 1, 0, 0, "R8 raw all");

        // R2 random interleaving
        for (int i = 0; i < 600; i++) begin
            int sel;
            sel = $urandom_range(0, 5);
            case (sel)
                0: op(1, 0, AW'($urandom_range(0, 20)), 0, 12'($urandom), "R2 rand read");
                1: op(1, 0, AW'(8 + $urandom_range(0, 11)), 0, 12'($urandom) & 12'h0F0, "R3 rand clr");
                2: op(1, 0, 5, 0, 0, "R4 rand clrall");
                3: op(0, 1, 0, 16'($urandom), 0, "R2 rand mask");
                4: levels(LW'($urandom), LW'($urandom));
                default: op(0, 1, AW'($urandom_range(3, 4)), 16'($urandom), 0, "R7 rand thr");
            endcase
        end
        op(1, 0, 2, 0, 0, "R2 final");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule